// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a synchronous I2C target. It runs on a fast system clock, samples the SCL and SDA lines through a synchroniser, and answers to one fixed 7-bit device address. Through an 8-bit pointer it gives a bus master read and write access to a 256-byte register space. The register space itself sits outside the block, behind a simple port. That port has an address, write data, a one-cycle write strobe, and read data that is returned combinationally.

The byte after the device address in a write transaction sets the pointer. The data bytes that follow are stored one after another. The pointer moves up by one after every byte written or read, and it keeps its value when a STOP ends the transaction. Because of this, a read sent straight after START returns data from the current pointer. A random read works by setting the pointer in a short write phase and then issuing a repeated START with the read direction. SDA is driven only by pulling it low.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high) at any point, including in the middle of a byte, restarts reception of the device-address byte. The bits of an interrupted byte are dropped and nothing is written.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: The first byte after START is received MSB first. Its upper 7 bits are compared with 7'b1000011, and its LSB selects the direction (1 = read, 0 = write). On a match, `sda_pull_o` is high through the 9th SCL high phase (acknowledge).
- R4: On an address mismatch the block does not drive SDA and does not assert `reg_we_o` until the next START.
- R5: `sda_pull_o` changes only while the synchronised SCL is low, except in the cycle after a START or a STOP.
- R6: In a write transaction, the byte after the device address is acknowledged and loads the pointer.
- R7: Each further byte in a write is acknowledged. It is presented for exactly one cycle on `reg_we_o`, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R8: The pointer advances by one, modulo 256, after every byte written or read. Apart from that it changes only when a sub-address byte loads it.
- R9: In a read, the block sends the byte at the pointer MSB first, with `sda_pull_o` high for each 0 bit. It releases SDA during the acknowledge slot.
- R10: When the master acknowledges a read byte, the next byte follows. When the master does not acknowledge (SDA high in the 9th slot), the block releases SDA and stays idle until the next START.
- R11: The pointer is kept across STOP and repeated START. A read right after START returns the byte at the kept pointer, and a write phase followed by a repeated START reads from the new sub-address.
- R12: After reset, SDA is released, `reg_we_o` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | High to pull SDA low (open drain) |
| reg_addr_o | output | 8 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
The assertions are checked on every cycle. They cover SDA being released after STOP and while idle, the address restart after START, SDA drive changing only while SCL is low, the single-cycle write strobe, the pointer moving only by one step or a sub-address load, and SDA being released in the master's acknowledge slot of a read. The bench scenarios are the only way to show that the correct bytes reach the correct addresses and come back MSB first. The same holds for the checks that an acknowledge appears only on an address match, that wrap-around at 255 works, and that the pointer survives STOP for a current-address read. A bit-level bus model predicts the SDA level for every SCL high phase and compares it on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_SUB,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic [AW-1:0] val_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= val_i;
    else if (inc_i)  ptr_o <= ptr_o + AW'(1);  // wraps modulo 2**AW
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic rd_nack, ptr_load, ptr_inc;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  always_comb begin
    ptr_load = (st == ST_SUB) && scl_fall && (bit_cnt == CNT_DATA);
    ptr_inc  = scl_fall && (((st == ST_WR) && (bit_cnt == CNT_ACK)) ||
                            ((st == ST_RD) && (bit_cnt == CNT_DATA)));
  end

  i2c_ptr_reg #(.AW(BYTE_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .inc_i(ptr_inc), .val_i(shreg),
    .ptr_o(reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      sda_pull_o  <= 1'b0;
      rd_nack     <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (start_det) begin
        st         <= ST_DEV;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        st         <= ST_IDLE;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (st != ST_RD && bit_cnt < CNT_DATA) shreg <= {shreg[BYTE_W-2:0], sda_s};
          if (st == ST_RD && bit_cnt == CNT_DATA) rd_nack <= sda_s;
        end else if (scl_fall) begin
          if (st == ST_RD) begin
            if (bit_cnt < CNT_DATA) begin
              shreg      <= shreg << 1;
              sda_pull_o <= ~shreg[BYTE_W-2];
            end else if (bit_cnt == CNT_DATA) begin
              sda_pull_o <= 1'b0;  // master's ack slot
            end else if (rd_nack) begin
              st <= ST_IDLE;
            end else begin
              shreg      <= reg_rdata_i;
              sda_pull_o <= ~reg_rdata_i[BYTE_W-1];
              bit_cnt    <= '0;
            end
          end else if (bit_cnt == CNT_DATA) begin
            if (st == ST_DEV && shreg[7:1] != DEV_ADDR) begin
              st <= ST_IDLE;
            end else begin
              sda_pull_o <= 1'b1;
              if (st == ST_WR) begin
                reg_we_o    <= 1'b1;
                reg_wdata_o <= shreg;
              end
            end
          end else if (bit_cnt == CNT_ACK) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            if (st == ST_DEV) begin
              if (shreg[0]) begin
                st         <= ST_RD;
                shreg      <= reg_rdata_i;
                sda_pull_o <= ~reg_rdata_i[BYTE_W-1];
              end else begin
                st <= ST_SUB;
              end
            end else if (st == ST_SUB) begin
              st <= ST_WR;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_pull_o,
  input logic             reg_we_o,
  input logic [7:0]       reg_addr_o,
  input tgt_state_e       st,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             start_det,
  input logic             stop_det,
  input logic             scl_s,
  input logic             ptr_load
);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(9);

  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st == ST_DEV) && (bit_cnt == '0));  // R1

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o && (st == ST_IDLE));  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_pull_o && !reg_we_o);  // R4

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);  // R5

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);  // R7

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(reg_addr_o) && !$past(ptr_load)) |-> reg_addr_o == 8'($past(reg_addr_o) + 8'd1));  // R8

  AST_RD_ACK_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_RD) && (bit_cnt == CNT_ACK)) |-> !sda_pull_o);  // R9
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_pull_o(sda_pull_o), .reg_we_o(reg_we_o),
  .reg_addr_o(reg_addr_o), .st(st), .bit_cnt(bit_cnt), .start_det(start_det),
  .stop_det(stop_det), .scl_s(scl_s), .ptr_load(ptr_load)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] regs [256];
  logic [7:0] ref_mem [256];
  logic [15:0] wq [$];
  logic exp_pull = 1'b0, chk_on = 1'b0;
  string mon_req = "R9";
  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  int ptr_m = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus   = sda_m & ~sda_pull;
  assign reg_rdata = regs[reg_addr];

  i2c_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  // register file and per-clock bus monitor
  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'(i * 37 + 5);
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && chk_on) begin
        m_chk++;
        if (sda_pull !== exp_pull) begin
          m_bad++;
          $display("FAIL %s sda drive actual %b expected %b at %0t", mon_req, sda_pull, exp_pull, $time);
        end
      end
      if (rst_n && reg_we) begin
        m_chk++;
        if (wq.size() == 0) begin
          m_bad++;
          $display("FAIL R4 unexpected write actual %h<=%h expected none", reg_addr, reg_wdata);
        end else begin
          logic [15:0] e;
          e = wq.pop_front();
          if ({reg_addr, reg_wdata} !== e) begin
            m_bad++;
            $display("FAIL R7 write actual %h<=%h expected %h<=%h", reg_addr, reg_wdata, e[15:8], e[7:0]);
          end
        end
        regs[reg_addr] = reg_wdata;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      $display("FAIL R1 watchdog cycles actual %0d expected < %0d", WD_CYCLES, WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk + 1, n_bad + m_bad + 1);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic mbit, input logic exp, output logic seen);
    sda_m = mbit;
    exp_pull = exp;
    wait_clk(Q);
    scl_m = 1'b1;
    chk_on = 1'b1;
    wait_clk(Q);
    seen = sda_bus;
    wait_clk(Q);
    chk_on = 1'b0;
    scl_m = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b0;
    wait_clk(Q);
    scl_m = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b1;
    wait_clk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    mon_req = req;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, s);
    bus_bit(1'b1, exp_ack, s);
    check8({req, " ack"}, {7'd0, ~s}, {7'd0, exp_ack});
  endtask

  task automatic read_byte(input logic mack, input string req);
    logic s;
    logic [7:0] got, exp_b;
    exp_b = ref_mem[ptr_m];
    mon_req = req;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~exp_b[i], s);
      got[i] = s;
    end
    bus_bit(~mack, 1'b0, s);
    check8(req, got, exp_b);
    ptr_m = (ptr_m + 1) % 256;
  endtask

  task automatic write_data(input logic [7:0] b, input string req);
    wq.push_back({8'(ptr_m), b});
    ref_mem[ptr_m] = b;
    send_byte(b, 1'b1, req);
    ptr_m = (ptr_m + 1) % 256;
  endtask

  task automatic set_sub(input logic [7:0] a);
    send_byte(a, 1'b1, "R6");
    ptr_m = a;
  endtask

  initial begin
    logic s;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 37 + 5);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R12 reset state
    check8("R12 sda_pull", {7'd0, sda_pull}, 8'd0);
    check8("R12 we", {7'd0, reg_we}, 8'd0);
    check8("R12 pointer", reg_addr, 8'd0);

    // byte write R3 R6 R7
    bus_start();
    send_byte(8'h86, 1'b1, "R3");
    set_sub(8'h10);
    write_data(8'hA5, "R7");
    bus_stop();

    // multibyte write across 255 -> 0 (R8)
    bus_start();
    send_byte(8'h86, 1'b1, "R3");
    set_sub(8'hFE);
    write_data(8'h11, "R7");
    write_data(8'h22, "R8");
    write_data(8'h33, "R8");
    bus_stop();
    check8("R8 wrapped pointer", reg_addr, 8'h01);

    // current-address read, master ack then nack (R9 R10 R11)
    bus_start();
    send_byte(8'h87, 1'b1, "R11");
    read_byte(1'b1, "R9");
    read_byte(1'b0, "R10");
    check8("R10 released after nack", {7'd0, sda_pull}, 8'd0);
    bus_stop();
    check8("R2 released after stop", {7'd0, sda_pull}, 8'd0);

    // random read via repeated START (R11)
    bus_start();
    send_byte(8'h86, 1'b1, "R3");
    set_sub(8'h10);
    bus_start();
    send_byte(8'h87, 1'b1, "R11");
    read_byte(1'b1, "R11");
    read_byte(1'b0, "R10");
    bus_stop();

    // address mismatch: no ack, no writes (R4)
    bus_start();
    send_byte(8'h44, 1'b0, "R4");
    send_byte(8'h99, 1'b0, "R4");
    send_byte(8'h77, 1'b0, "R4");
    bus_stop();
    check8("R4 pointer untouched", reg_addr, 8'(ptr_m));

    // near-miss address (LSB of address differs) R3
    bus_start();
    send_byte(8'h84, 1'b0, "R3");
    bus_stop();

    // current read shows pointer kept across STOP (R11)
    bus_start();
    send_byte(8'h87, 1'b1, "R11");
    read_byte(1'b0, "R11");
    bus_stop();

    // repeated START mid-byte aborts the byte (R1)
    bus_start();
    send_byte(8'h86, 1'b1, "R3");
    set_sub(8'h40);
    mon_req = "R1";
    bus_bit(1'b0, 1'b0, s);
    bus_bit(1'b1, 1'b0, s);
    bus_bit(1'b0, 1'b0, s);
    bus_start();
    send_byte(8'h87, 1'b1, "R1");
    read_byte(1'b1, "R1");
    read_byte(1'b0, "R10");
    bus_stop();
    check8("R8 pointer after reads", reg_addr, 8'h42);

    // pointer persists for a fresh current read (R11)
    bus_start();
    send_byte(8'h87, 1'b1, "R11");
    read_byte(1'b0, "R11");
    bus_stop();

    wait_clk(4);
    check8("R7 pending writes", 8'(wq.size()), 8'd0);
    check8("R1 write landed", regs[8'h10], 8'hA5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end
endmodule